// File: doc/BRIEF.md
# Filter Predict-Step Sequencer

This block is the control state machine for the predict phase of a sigma-point filter accelerator. A processor first writes the transformed sigma points into a shared serial buffer. It then issues a start command. The sequencer runs four external datapath units in a fixed order: a prefetch unit that moves the points into parallel storage, a mean unit, a residual unit and a covariance unit. Each unit gets a one-cycle start pulse. The sequencer waits for that unit's ready before it moves to the next stage.

While the mean stage is active, every result word from the mean unit goes to two places: the internal augmented-state memory and the shared buffer. While the covariance stage is active, every covariance word likewise goes to the internal augmented-covariance memory and to the shared buffer. When the covariance unit reports ready, the sequencer returns to idle and sets a sticky completion flag. If the build parameter enables it, the sequencer also raises a one-cycle interrupt. The processor clears the flag by writing a one. A new run cannot start until the flag is clear.

Top module: `predict_sequencer`

## Requirements
- R1: After synchronous reset, busy, done_flag and irq are 0, and no unit start pulse and no memory write is issued.
- R2: When start_cmd is high in idle with done_flag low, pf_start is high for exactly one cycle in the next cycle, and busy is high from that cycle until the run ends.
- R3: Unit starts are issued in the order prefetch, mean, residuals, covariance. Each start is a single-cycle pulse in the first cycle of its stage, and each unit is started exactly once per run.
- R4: A stage holds while its own unit's ready is low. The next unit's start appears only in the cycle after the current unit's ready was high. A ready from a unit that is not active has no effect.
- R5: cov_start is issued only in the cycle after res_rdy was high in the residual stage.
- R6: A mean word (mean_vld high during the mean stage) appears one cycle later as a write to the state memory at address mean_idx, and as a write to the buffer at address MEAN_BASE + mean_idx, both with the same data.
- R7: A covariance word (cov_vld high during the covariance stage) appears one cycle later as a write to the covariance memory at address cov_idx, and as a write to the buffer at address COV_BASE + cov_idx, both with the same data.
- R8: mean_vld outside the mean stage, and cov_vld outside the covariance stage, produce no memory or buffer write.
- R9: In the cycle after cov_rdy is sampled in the covariance stage, busy is 0 and done_flag is 1.
- R10: done_flag stays set until clr_done is high, and is 0 from the next cycle. clr_done has no effect when the flag is already clear.
- R11: start_cmd is ignored while busy or while done_flag is set.
- R12: With IRQ_EN set, irq is a one-cycle pulse in the same cycle that done_flag rises, once per run. With IRQ_EN clear, irq stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_cmd | input | 1 | Processor predict start command |
| clr_done | input | 1 | Write-one-to-clear of the completion flag |
| busy | output | 1 | A run is in progress |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion interrupt |
| pf_start | output | 1 | Start pulse to the prefetch unit |
| pf_rdy | input | 1 | Prefetch unit finished |
| mean_start | output | 1 | Start pulse to the mean unit |
| mean_rdy | input | 1 | Mean unit finished |
| res_start | output | 1 | Start pulse to the residual unit |
| res_rdy | input | 1 | Residual unit finished |
| cov_start | output | 1 | Start pulse to the covariance unit |
| cov_rdy | input | 1 | Covariance unit finished |
| mean_vld | input | 1 | Mean result word valid |
| mean_idx | input | MIDX_W | Mean element index |
| mean_data | input | DATA_W | Mean element value |
| cov_vld | input | 1 | Covariance result word valid |
| cov_idx | input | CIDX_W | Covariance element index |
| cov_data | input | DATA_W | Covariance element value |
| st_we | output | 1 | Augmented-state memory write enable |
| st_addr | output | MIDX_W | Augmented-state memory address |
| st_wdata | output | DATA_W | Augmented-state memory data |
| cv_we | output | 1 | Augmented-covariance memory write enable |
| cv_addr | output | CIDX_W | Augmented-covariance memory address |
| cv_wdata | output | DATA_W | Augmented-covariance memory data |
| buf_we | output | 1 | Shared buffer write enable |
| buf_addr | output | BUF_AW | Shared buffer address |
| buf_wdata | output | DATA_W | Shared buffer data |

## Verification
The hardest case to reach from the ports is a unit that raises ready or valid while it is not the active stage. A correct external unit never does this, so a normal run never exercises the stage gating. The bench has a stray mode in which every inactive unit toggles its ready line and pushes result words with recognisable data. This makes ready and valid arrive during the wrong stages, and sometimes in the same cycle as the genuine ready of the active unit. The bench then confirms that the stage order is unchanged and that no such word reaches any memory. Start commands are also sent mid-run and while the flag is still set. A clear is sent in the same cycle as a new start, which shows that the refusal depends on the flag value before the clear takes effect.

// File: rtl/pred_seq_pkg.sv
package pred_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_FETCH = 3'd1,
        PH_MEAN  = 3'd2,
        PH_RESID = 3'd3,
        PH_COVAR = 3'd4
    } phase_e;

    localparam int NUM_UNITS  = 4;
    localparam int UNIT_W     = $clog2(NUM_UNITS);
    localparam int UNIT_FETCH = 0;
    localparam int UNIT_MEAN  = 1;
    localparam int UNIT_RESID = 2;
    localparam int UNIT_COVAR = 3;

    // Index of the unit that a working phase waits on.
    function automatic logic [UNIT_W-1:0] unit_of(phase_e p);
        case (p)
            PH_MEAN:  return UNIT_W'(UNIT_MEAN);
            PH_RESID: return UNIT_W'(UNIT_RESID);
            PH_COVAR: return UNIT_W'(UNIT_COVAR);
            default:  return UNIT_W'(UNIT_FETCH);
        endcase
    endfunction

    // Phase in which a given unit works.
    function automatic phase_e phase_of_unit(int u);
        return phase_e'(3'(u + 1));
    endfunction

    // Phase that follows a working phase once its unit is ready.
    function automatic phase_e next_phase(phase_e p);
        case (p)
            PH_FETCH: return PH_MEAN;
            PH_MEAN:  return PH_RESID;
            PH_RESID: return PH_COVAR;
            default:  return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/pred_phase_fsm.sv
module pred_phase_fsm
    import pred_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_ok,
    input  logic [NUM_UNITS-1:0] rdy_vec,
    output phase_e               phase_o,
    output logic [NUM_UNITS-1:0] go_o,
    output logic                 finish_o
);

    phase_e               phase_q;
    phase_e               phase_d;
    logic                 cur_rdy;
    logic                 advance;
    logic [NUM_UNITS-1:0] go_d;
    logic [NUM_UNITS-1:0] go_q;

    assign cur_rdy = rdy_vec[unit_of(phase_q)];

    always_comb begin
        advance = 1'b0;
        phase_d = phase_q;
        if (phase_q == PH_IDLE) begin
            if (start_ok) begin
                advance = 1'b1;
                phase_d = PH_FETCH;
            end
        end else if (cur_rdy) begin
            advance = 1'b1;
            phase_d = next_phase(phase_q);
        end
    end

    // One start pulse per unit, fired on entry to its phase.
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_go
        assign go_d[u] = advance && (phase_d == phase_of_unit(u));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            go_q    <= '0;
        end else begin
            phase_q <= phase_d;
            go_q    <= go_d;
        end
    end

    assign phase_o  = phase_q;
    assign go_o     = go_q;
    assign finish_o = (phase_q == PH_COVAR) && cur_rdy;

    AST_GO_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (|go_q) |-> (phase_q != $past(phase_q))); // R3
    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(go_q)); // R3
    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && !cur_rdy) |=> $stable(phase_q)); // R4
    AST_COV_AFTER_RESID: assert property (@(posedge clk) disable iff (rst)
        go_q[UNIT_COVAR] |-> ($past(phase_q) == PH_RESID && $past(rdy_vec[UNIT_RESID]))); // R5
    AST_IDLE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && !start_ok) |=> (phase_q == PH_IDLE)); // R11

endmodule

// File: rtl/pred_writeback.sv
module pred_writeback
    import pred_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MIDX_W = 4,
    parameter int CIDX_W = 8,
    parameter int BUF_AW = 10,
    parameter logic [BUF_AW-1:0] MEAN_BASE = 10'h040,
    parameter logic [BUF_AW-1:0] COV_BASE  = 10'h100
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic              mean_vld,
    input  logic [MIDX_W-1:0] mean_idx,
    input  logic [DATA_W-1:0] mean_data,
    input  logic              cov_vld,
    input  logic [CIDX_W-1:0] cov_idx,
    input  logic [DATA_W-1:0] cov_data,
    output logic              st_we,
    output logic [MIDX_W-1:0] st_addr,
    output logic [DATA_W-1:0] st_wdata,
    output logic              cv_we,
    output logic [CIDX_W-1:0] cv_addr,
    output logic [DATA_W-1:0] cv_wdata,
    output logic              buf_we,
    output logic [BUF_AW-1:0] buf_addr,
    output logic [DATA_W-1:0] buf_wdata
);

    typedef struct packed {
        logic              we;
        logic [BUF_AW-1:0] addr;
        logic [DATA_W-1:0] data;
    } buf_wr_t;

    logic    mean_acc;
    logic    cov_acc;
    buf_wr_t buf_d;
    buf_wr_t buf_q;

    assign mean_acc = (phase == PH_MEAN) && mean_vld;
    assign cov_acc  = (phase == PH_COVAR) && cov_vld;

    always_comb begin
        buf_d.we = mean_acc || cov_acc;
        if (mean_acc) begin
            buf_d.addr = MEAN_BASE + BUF_AW'(mean_idx);
            buf_d.data = mean_data;
        end else begin
            buf_d.addr = COV_BASE + BUF_AW'(cov_idx);
            buf_d.data = cov_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_we    <= 1'b0;
            st_addr  <= '0;
            st_wdata <= '0;
            cv_we    <= 1'b0;
            cv_addr  <= '0;
            cv_wdata <= '0;
            buf_q    <= '0;
        end else begin
            st_we    <= mean_acc;
            st_addr  <= mean_idx;
            st_wdata <= mean_data;
            cv_we    <= cov_acc;
            cv_addr  <= cov_idx;
            cv_wdata <= cov_data;
            buf_q    <= buf_d;
        end
    end

    assign buf_we    = buf_q.we;
    assign buf_addr  = buf_q.addr;
    assign buf_wdata = buf_q.data;

    AST_STATE_WR_IN_MEAN: assert property (@(posedge clk) disable iff (rst)
        st_we |-> ($past(phase) == PH_MEAN)); // R8
    AST_COV_WR_IN_COVAR: assert property (@(posedge clk) disable iff (rst)
        cv_we |-> ($past(phase) == PH_COVAR)); // R8
    AST_BUF_MIRRORS_STATE: assert property (@(posedge clk) disable iff (rst)
        st_we |-> (buf_we && buf_wdata == st_wdata)); // R6
    AST_BUF_MIRRORS_COV: assert property (@(posedge clk) disable iff (rst)
        cv_we |-> (buf_we && buf_wdata == cv_wdata)); // R7

endmodule

// File: rtl/pred_status.sv
module pred_status #(
    parameter bit IRQ_EN = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic finish,
    input  logic clr,
    output logic done,
    output logic irq
);

    logic done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
        end else if (finish) begin
            done_q <= 1'b1;
        end else if (clr) begin
            done_q <= 1'b0;
        end
    end

    assign done = done_q;

    if (IRQ_EN) begin : g_irq
        logic irq_q;
        always_ff @(posedge clk) begin
            if (rst) irq_q <= 1'b0;
            else     irq_q <= finish;
        end
        assign irq = irq_q;

        AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
            irq_q |-> (done_q && !$past(done_q))); // R12
        AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
            irq_q |=> !irq_q); // R12
    end else begin : g_no_irq
        assign irq = 1'b0;
    end

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (done_q && !clr) |=> done_q); // R10
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (done_q && clr && !finish) |=> !done_q); // R10

endmodule

// File: rtl/predict_sequencer.sv
module predict_sequencer
    import pred_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MIDX_W = 4,
    parameter int CIDX_W = 8,
    parameter int BUF_AW = 10,
    parameter logic [BUF_AW-1:0] MEAN_BASE = 10'h040,
    parameter logic [BUF_AW-1:0] COV_BASE  = 10'h100,
    parameter bit IRQ_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_cmd,
    input  logic              clr_done,
    output logic              busy,
    output logic              done_flag,
    output logic              irq,
    output logic              pf_start,
    input  logic              pf_rdy,
    output logic              mean_start,
    input  logic              mean_rdy,
    output logic              res_start,
    input  logic              res_rdy,
    output logic              cov_start,
    input  logic              cov_rdy,
    input  logic              mean_vld,
    input  logic [MIDX_W-1:0] mean_idx,
    input  logic [DATA_W-1:0] mean_data,
    input  logic              cov_vld,
    input  logic [CIDX_W-1:0] cov_idx,
    input  logic [DATA_W-1:0] cov_data,
    output logic              st_we,
    output logic [MIDX_W-1:0] st_addr,
    output logic [DATA_W-1:0] st_wdata,
    output logic              cv_we,
    output logic [CIDX_W-1:0] cv_addr,
    output logic [DATA_W-1:0] cv_wdata,
    output logic              buf_we,
    output logic [BUF_AW-1:0] buf_addr,
    output logic [DATA_W-1:0] buf_wdata
);

    phase_e               phase;
    logic [NUM_UNITS-1:0] rdy_vec;
    logic [NUM_UNITS-1:0] go;
    logic                 finish;
    logic                 start_ok;

    assign rdy_vec  = {cov_rdy, res_rdy, mean_rdy, pf_rdy};
    assign start_ok = start_cmd && !done_flag;

    pred_phase_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start_ok (start_ok),
        .rdy_vec  (rdy_vec),
        .phase_o  (phase),
        .go_o     (go),
        .finish_o (finish)
    );

    pred_writeback #(
        .DATA_W    (DATA_W),
        .MIDX_W    (MIDX_W),
        .CIDX_W    (CIDX_W),
        .BUF_AW    (BUF_AW),
        .MEAN_BASE (MEAN_BASE),
        .COV_BASE  (COV_BASE)
    ) u_wb (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .mean_vld  (mean_vld),
        .mean_idx  (mean_idx),
        .mean_data (mean_data),
        .cov_vld   (cov_vld),
        .cov_idx   (cov_idx),
        .cov_data  (cov_data),
        .st_we     (st_we),
        .st_addr   (st_addr),
        .st_wdata  (st_wdata),
        .cv_we     (cv_we),
        .cv_addr   (cv_addr),
        .cv_wdata  (cv_wdata),
        .buf_we    (buf_we),
        .buf_addr  (buf_addr),
        .buf_wdata (buf_wdata)
    );

    pred_status #(
        .IRQ_EN (IRQ_EN)
    ) u_status (
        .clk    (clk),
        .rst    (rst),
        .finish (finish),
        .clr    (clr_done),
        .done   (done_flag),
        .irq    (irq)
    );

    assign busy       = (phase != PH_IDLE);
    assign pf_start   = go[UNIT_FETCH];
    assign mean_start = go[UNIT_MEAN];
    assign res_start  = go[UNIT_RESID];
    assign cov_start  = go[UNIT_COVAR];

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        pf_start |-> busy); // R2
    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> !busy); // R9

endmodule

// File: tb/sim_predict_sequencer.sv
`timescale 1ns/1ps
module sim_predict_sequencer;

    localparam int DW = 32;
    localparam int MW = 4;
    localparam int CW = 8;
    localparam int AW = 10;
    localparam int MBASE = 64;
    localparam int CBASE = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_cmd = 1'b0, clr_done = 1'b0;
    logic busy, done_flag, irq;
    logic pf_start, mean_start, res_start, cov_start;
    logic pf_rdy = 1'b0, mean_rdy = 1'b0, res_rdy = 1'b0, cov_rdy = 1'b0;
    logic mean_vld = 1'b0, cov_vld = 1'b0;
    logic [MW-1:0] mean_idx = '0;
    logic [CW-1:0] cov_idx = '0;
    logic [DW-1:0] mean_data = '0, cov_data = '0;
    logic st_we, cv_we, buf_we;
    logic [MW-1:0] st_addr;
    logic [CW-1:0] cv_addr;
    logic [AW-1:0] buf_addr;
    logic [DW-1:0] st_wdata, cv_wdata, buf_wdata;

    always #10 clk = ~clk;

    predict_sequencer u0 (
        .clk(clk), .rst(rst), .start_cmd(start_cmd), .clr_done(clr_done),
        .busy(busy), .done_flag(done_flag), .irq(irq),
        .pf_start(pf_start), .pf_rdy(pf_rdy),
        .mean_start(mean_start), .mean_rdy(mean_rdy),
        .res_start(res_start), .res_rdy(res_rdy),
        .cov_start(cov_start), .cov_rdy(cov_rdy),
        .mean_vld(mean_vld), .mean_idx(mean_idx), .mean_data(mean_data),
        .cov_vld(cov_vld), .cov_idx(cov_idx), .cov_data(cov_data),
        .st_we(st_we), .st_addr(st_addr), .st_wdata(st_wdata),
        .cv_we(cv_we), .cv_addr(cv_addr), .cv_wdata(cv_wdata),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata)
    );

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_state = 0;       // 0 idle,1 prefetch,2 mean,3 residual,4 covariance
    bit  m_done = 0;
    bit  e_irq = 0;
    bit  [3:0] e_go = 0;
    bit  e_st_we = 0, e_cv_we = 0, e_buf_we = 0;
    int  e_st_addr = 0, e_cv_addr = 0, e_buf_addr = 0;
    longint e_st_data = 0, e_cv_data = 0, e_buf_data = 0;

    always @(posedge clk) begin
        bit [3:0] rd;
        bit fin;
        rd = {cov_rdy, res_rdy, mean_rdy, pf_rdy};
        if (rst) begin
            m_state = 0; m_done = 0; e_irq = 0; e_go = 0;
            e_st_we = 0; e_cv_we = 0; e_buf_we = 0;
        end else begin
            e_st_we = (m_state == 2) && mean_vld;
            e_cv_we = (m_state == 4) && cov_vld;
            e_st_addr = mean_idx; e_st_data = mean_data;
            e_cv_addr = cov_idx;  e_cv_data = cov_data;
            e_buf_we = e_st_we || e_cv_we;
            e_buf_addr = e_st_we ? MBASE + mean_idx : CBASE + cov_idx;
            e_buf_data = e_st_we ? mean_data : cov_data;
            e_go = 0; fin = 0;
            if (m_state == 0) begin
                if (start_cmd && !m_done) begin m_state = 1; e_go[0] = 1; end
            end else if (rd[m_state-1]) begin
                if (m_state == 4) begin m_state = 0; fin = 1; end
                else begin e_go[m_state] = 1; m_state++; end
            end
            e_irq = fin;
            if (fin) m_done = 1;
            else if (clr_done) m_done = 0;
        end
    end

    // ---------------- responder / driver state ----------------
    int  cnt[4] = '{-1, -1, -1, -1};
    int  dly[4] = '{0, 0, 0, 0};
    bit  stray_on = 0;
    bit  start_req = 0, clr_req = 0;
    bit  [3:0] p_rdy = 0;
    bit  p_stray_m = 0, p_stray_c = 0;
    int  cyc = 0, mseq = 0, cseq = 0;
    int  n_pf = 0, n_irq = 0;

    task automatic compare();
        bit [3:0] g;
        g = {cov_start, res_start, mean_start, pf_start};
        chk(busy === (m_state != 0), "R2", "busy", busy, m_state != 0);
        chk(done_flag === m_done, "R9", "done_flag", done_flag, m_done);
        chk(irq === e_irq, "R12", "irq", irq, e_irq);
        chk(g === e_go, "R3", "unit starts", g, e_go);
        chk(st_we === e_st_we && (!e_st_we || (st_addr == e_st_addr && st_wdata == e_st_data)),
            "R6", "state write", {st_we, st_addr, st_wdata}, {e_st_we, 4'(e_st_addr), 32'(e_st_data)});
        chk(cv_we === e_cv_we && (!e_cv_we || (cv_addr == e_cv_addr && cv_wdata == e_cv_data)),
            "R7", "cov write", {cv_we, cv_addr, cv_wdata}, {e_cv_we, 8'(e_cv_addr), 32'(e_cv_data)});
        chk(buf_we === e_buf_we && (!e_buf_we || (buf_addr == e_buf_addr && buf_wdata == e_buf_data)),
            "R6/R7", "buffer write", {buf_we, buf_addr, buf_wdata}, {e_buf_we, 10'(e_buf_addr), 32'(e_buf_data)});
    endtask

    task automatic step();
        bit [3:0] g, act, rn;
        @(negedge clk);
        cyc++;
        compare();
        g = {cov_start, res_start, mean_start, pf_start};
        // R4: a later unit starts only after the previous unit's ready
        chk(!g[1] || p_rdy[0], "R4", "mean_start after pf_rdy", g[1], p_rdy[0]);
        chk(!g[2] || p_rdy[1], "R4", "res_start after mean_rdy", g[2], p_rdy[1]);
        // R5: covariance only after residuals ready
        chk(!g[3] || p_rdy[2], "R5", "cov_start after res_rdy", g[3], p_rdy[2]);
        // R8: stray words are not written
        if (p_stray_m) chk(!st_we, "R8", "stray mean write", st_we, 0);
        if (p_stray_c) chk(!cv_we, "R8", "stray cov write", cv_we, 0);
        if (pf_start) n_pf++;
        if (irq) n_irq++;
        for (int u = 0; u < 4; u++) if (g[u]) cnt[u] = dly[u];
        for (int u = 0; u < 4; u++) begin
            act[u] = cnt[u] >= 0;
            rn[u] = 0;
            if (cnt[u] == 0) begin rn[u] = 1; cnt[u] = -1; end
            else if (cnt[u] > 0) cnt[u]--;
            if (stray_on && !act[u]) rn[u] = cyc[0];
        end
        {cov_rdy, res_rdy, mean_rdy, pf_rdy} = rn;
        p_rdy = rn;
        mean_vld = act[1] || (stray_on && cyc[1]);
        mean_idx = MW'(mseq);
        mean_data = act[1] ? 32'hA000_0000 + cyc : 32'hDEAD_0000 + cyc;
        if (act[1]) mseq++;
        cov_vld = act[3] || (stray_on && !cyc[1]);
        cov_idx = CW'(cseq);
        cov_data = act[3] ? 32'hC000_0000 + cyc : 32'hBEEF_0000 + cyc;
        if (act[3]) cseq++;
        p_stray_m = mean_vld && (m_state != 2);
        p_stray_c = cov_vld && (m_state != 4);
        start_cmd = start_req; start_req = 0;
        clr_done = clr_req; clr_req = 0;
    endtask

    task automatic run(int d0, int d1, int d2, int d3, bit restart_mid);
        int pf0, irq0, guard;
        dly = '{d0, d1, d2, d3};
        pf0 = n_pf; irq0 = n_irq;
        start_req = 1;
        step();                       // start driven this cycle
        step();
        chk(pf_start && busy, "R2", "pf_start/busy after start", {pf_start, busy}, 2'b11);
        if (restart_mid) start_req = 1;   // R11 while busy
        guard = 0;
        while (m_state != 0 && guard < 300) begin step(); guard++; end
        chk(!busy && done_flag, "R9", "end of run busy/done", {busy, done_flag}, 2'b01);
        step();
        chk(n_pf - pf0 == 1, "R11", "prefetch starts per run", n_pf - pf0, 1);
        chk(n_irq - irq0 == 1, "R12", "irq pulses per run", n_irq - irq0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done_flag && !irq, "R1", "status after reset", {busy, done_flag, irq}, 0);
        chk({pf_start, mean_start, res_start, cov_start} == 0, "R1", "starts after reset",
            {pf_start, mean_start, res_start, cov_start}, 0);
        chk(!st_we && !cv_we && !buf_we, "R1", "writes after reset", {st_we, cv_we, buf_we}, 0);

        run(0, 0, 0, 0, 0);
        // R11: start refused while done is set
        start_req = 1; step(); step(); step();
        chk(!busy && done_flag, "R11", "start ignored while done", {busy, done_flag}, 2'b01);
        // R10: clear and hold
        clr_req = 1; step(); step();
        chk(!done_flag, "R10", "done cleared", done_flag, 0);
        clr_req = 1; step(); step();
        chk(!done_flag && !busy, "R10", "clear when already clear", {done_flag, busy}, 0);

        run(3, 5, 2, 7, 1);
        // clear and start in the same cycle: start is still refused
        clr_req = 1; start_req = 1; step(); step(); step();
        chk(!busy && !done_flag, "R11", "start with simultaneous clear", {busy, done_flag}, 0);

        stray_on = 1;
        run(4, 6, 3, 9, 0);
        clr_req = 1; step(); step();
        run(1, 2, 5, 3, 1);
        stray_on = 0;
        clr_req = 1; step();
        run(6, 1, 1, 12, 0);
        clr_req = 1; step(); step();
        chk(!done_flag, "R10", "final clear", done_flag, 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule